// File: doc/BRIEF.md
# Mailbox segment reassembly validator

This block sits on the receive side of a mailbox channel. Each cycle it may be handed one segment: the decoded header fields plus up to 48 payload bytes presented in parallel. It validates the segment against the state of the message currently being rebuilt in the matching descriptor. A segment that passes has its payload forwarded to a write port of an external reassembly buffer. Each descriptor owns 43 lines of 48 bytes in that buffer, so one line holds one segment. When the segment flagged as last passes, the message length and status carried in its header are latched and presented with a completion pulse.

Four descriptors exist. Request and response traffic are tracked apart, and so are segments from the management function and segments from any other function. A response waiter holds the id of one outstanding request. A response that completes with that id while the waiter is armed produces a single match pulse and disarms the waiter.

Any broken rule poisons the descriptor. After that, only a fresh segment with sequence number 0 can start it again.

Top module: `mbx_seg_reasm`

## Requirements
- R1: A segment whose sequence number is above 42, or whose length is above 48 bytes, is rejected: `seg_err_o` pulses and nothing is written.
- R2: A segment with sequence number 42 is rejected when its length exceeds 32 bytes, and accepted at exactly 32 bytes, so a message never exceeds 2048 bytes.
- R3: A segment with sequence number 0 that passes the range checks is always accepted, and its message id, module and command become the descriptor's reference.
- R4: A segment with a nonzero sequence number is accepted only if that number is the descriptor's previous number plus one and its message id, module and command all equal the reference. Otherwise it is rejected.
- R5: A rejected segment poisons its descriptor. Every later nonzero segment to that descriptor is rejected until a sequence-0 segment restarts it.
- R6: For an accepted segment, `wr_line_o` equals its sequence number (byte offset sequence times 48). `wr_be_o` bit i is 1 exactly when i is below the segment length. `wr_data_o` carries the payload unchanged.
- R7: An accepted segment with the last flag set raises `msg_done_o`. It also presents the header's message length and status on `done_len_o` and `done_stat_o`, and the descriptor on `done_sel_o`.
- R8: The descriptor index is {direction, source == 0x1FFF}, with direction 1 meaning response. Descriptors keep separate state, so segments of different descriptors may interleave.
- R9: `req_start_i` arms the waiter with `req_id_i`. An accepted last response segment whose message id equals the armed id pulses `rsp_match_o` and disarms the waiter. Further matching responses produce no pulse until the waiter is armed again.
- R10: After reset every output is 0 and every descriptor is poisoned, so a nonzero segment arriving first is rejected.
- R11: Every output pulse is one cycle wide and lies one cycle after a segment. `wr_en_o` and `seg_err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_valid_i | input | 1 | A segment is presented this cycle |
| seg_dir_i | input | 1 | 0 request, 1 response |
| seg_src_i | input | 13 | Source function id |
| seg_seq_i | input | 6 | Sequence number of the segment |
| seg_len_i | input | 6 | Payload bytes in the segment |
| seg_last_i | input | 1 | Segment ends its message |
| seg_mid_i | input | 4 | Message id |
| seg_mod_i | input | 8 | Module code |
| seg_cmd_i | input | 16 | Command code |
| seg_mlen_i | input | 12 | Total message length from the header |
| seg_stat_i | input | 8 | Status from the header |
| seg_data_i | input | 384 | Payload, byte i at bits 8i+7:8i |
| req_start_i | input | 1 | Arm the response waiter |
| req_id_i | input | 4 | Message id awaited |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_sel_o | output | 2 | Descriptor written |
| wr_line_o | output | 6 | Line within the descriptor's region |
| wr_be_o | output | 48 | Byte enables |
| wr_data_o | output | 384 | Write data |
| seg_err_o | output | 1 | Segment rejected |
| msg_done_o | output | 1 | Message completed |
| done_sel_o | output | 2 | Descriptor completed |
| done_len_o | output | 12 | Latched message length |
| done_stat_o | output | 8 | Latched status |
| rsp_match_o | output | 1 | Awaited response arrived |

## Verification
All results are registered once. The write port, error pulse, completion fields and match pulse for a segment presented before a rising edge are all visible just after that edge. A segment presented in one cycle therefore shows its outcome in the next cycle, and a following segment already sees the updated descriptor. The bench model applies the same one-edge latency: it updates on the rising edge and compares on the falling edge. Because of that, every cycle is checked, including idle cycles, where all pulses must be low.

// File: rtl/mbx_reasm_pkg.sv
package mbx_reasm_pkg;
  localparam int SEQ_W  = 6;
  localparam int LEN_W  = 6;
  localparam int MID_W  = 4;
  localparam int MOD_W  = 8;
  localparam int CMD_W  = 16;
  localparam int FUNC_W = 13;
  localparam int MLEN_W = 12;
  localparam int STAT_W = 8;
  localparam int NDESC  = 4;
  localparam int SEL_W  = $clog2(NDESC);

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [MID_W-1:0] mid;
    logic [MOD_W-1:0] modl;
    logic [CMD_W-1:0] cmd;
  } desc_t;
endpackage

// File: rtl/mbx_seg_rules.sv
module mbx_seg_rules
  import mbx_reasm_pkg::*;
#(
  parameter int MAX_SEQ   = 42,
  parameter int SEG_BYTES = 48,
  parameter int LAST_MAX  = 32
) (
  input  desc_t            cur_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [MID_W-1:0] mid_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             ok_o,
  output logic             first_o
);
  logic             range_bad;
  logic             cont_ok;
  logic [SEQ_W:0]   want_seq;

  always_comb begin
    range_bad = (seq_i > SEQ_W'(MAX_SEQ)) || (len_i > LEN_W'(SEG_BYTES)) ||
                ((seq_i == SEQ_W'(MAX_SEQ)) && (len_i > LEN_W'(LAST_MAX)));
    want_seq  = {1'b0, cur_i.seq} + 1'b1;
    cont_ok   = ({1'b0, seq_i} == want_seq) && (mid_i == cur_i.mid) &&
                (mod_i == cur_i.modl) && (cmd_i == cur_i.cmd);
    first_o   = (seq_i == '0);
    ok_o      = !range_bad && (first_o || cont_ok);
  end
endmodule

// File: rtl/mbx_desc_store.sv
module mbx_desc_store
  import mbx_reasm_pkg::*;
#(
  parameter int MAX_SEQ = 42
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ok_i,
  input  logic             first_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [MID_W-1:0] mid_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [CMD_W-1:0] cmd_i,
  output desc_t            cur_o
);
  desc_t bank [NDESC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < NDESC; d++) begin
        bank[d].seq  <= SEQ_W'(MAX_SEQ);
        bank[d].mid  <= '0;
        bank[d].modl <= '0;
        bank[d].cmd  <= '0;
      end
    end else if (upd_i) begin
      if (!ok_i) begin
        bank[sel_i].seq <= SEQ_W'(MAX_SEQ);
      end else if (first_i) begin
        bank[sel_i].seq  <= seq_i;
        bank[sel_i].mid  <= mid_i;
        bank[sel_i].modl <= mod_i;
        bank[sel_i].cmd  <= cmd_i;
      end else begin
        bank[sel_i].seq <= seq_i;
      end
    end
  end

  assign cur_o = bank[sel_i];

  // R5
  poison_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !ok_i) |=> (bank[$past(sel_i)].seq == SEQ_W'(MAX_SEQ)));
endmodule

// File: rtl/mbx_resp_waiter.sv
module mbx_resp_waiter
  import mbx_reasm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_start_i,
  input  logic [MID_W-1:0] req_id_i,
  input  logic             hit_i,
  input  logic [MID_W-1:0] hit_id_i,
  output logic             match_o
);
  logic             armed;
  logic [MID_W-1:0] pend_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      pend_id <= '0;
      match_o <= 1'b0;
    end else begin
      match_o <= 1'b0;
      if (req_start_i) begin
        armed   <= 1'b1;
        pend_id <= req_id_i;
      end else if (hit_i && armed && (hit_id_i == pend_id)) begin
        match_o <= 1'b1;
        armed   <= 1'b0;
      end
    end
  end

  // R9
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |-> !armed || $past(req_start_i));
endmodule

// File: rtl/mbx_seg_reasm.sv
module mbx_seg_reasm
  import mbx_reasm_pkg::*;
#(
  parameter int               SEG_BYTES = 48,
  parameter int               BUF_BYTES = 2048,
  parameter logic [FUNC_W-1:0] MGMT_FUNC = 13'h1FFF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   seg_valid_i,
  input  logic                   seg_dir_i,
  input  logic [FUNC_W-1:0]      seg_src_i,
  input  logic [SEQ_W-1:0]       seg_seq_i,
  input  logic [LEN_W-1:0]       seg_len_i,
  input  logic                   seg_last_i,
  input  logic [MID_W-1:0]       seg_mid_i,
  input  logic [MOD_W-1:0]       seg_mod_i,
  input  logic [CMD_W-1:0]       seg_cmd_i,
  input  logic [MLEN_W-1:0]      seg_mlen_i,
  input  logic [STAT_W-1:0]      seg_stat_i,
  input  logic [SEG_BYTES*8-1:0] seg_data_i,
  input  logic                   req_start_i,
  input  logic [MID_W-1:0]       req_id_i,
  output logic                   wr_en_o,
  output logic [SEL_W-1:0]       wr_sel_o,
  output logic [SEQ_W-1:0]       wr_line_o,
  output logic [SEG_BYTES-1:0]   wr_be_o,
  output logic [SEG_BYTES*8-1:0] wr_data_o,
  output logic                   seg_err_o,
  output logic                   msg_done_o,
  output logic [SEL_W-1:0]       done_sel_o,
  output logic [MLEN_W-1:0]      done_len_o,
  output logic [STAT_W-1:0]      done_stat_o,
  output logic                   rsp_match_o
);
  localparam int MAX_SEQ  = BUF_BYTES / SEG_BYTES;
  localparam int LAST_MAX = BUF_BYTES - MAX_SEQ * SEG_BYTES;

  logic [SEL_W-1:0]     sel;
  desc_t                cur;
  logic                 ok;
  logic                 first;
  logic                 take;
  logic [SEG_BYTES-1:0] be_next;

  assign sel  = {seg_dir_i, (seg_src_i == MGMT_FUNC)};
  assign take = seg_valid_i && ok;

  for (genvar b = 0; b < SEG_BYTES; b++) begin : g_be
    assign be_next[b] = (32'(seg_len_i) > b);
  end

  mbx_desc_store #(.MAX_SEQ(MAX_SEQ)) u_store (
    .clk(clk), .rst(rst), .upd_i(seg_valid_i), .sel_i(sel), .ok_i(ok),
    .first_i(first), .seq_i(seg_seq_i), .mid_i(seg_mid_i), .mod_i(seg_mod_i),
    .cmd_i(seg_cmd_i), .cur_o(cur)
  );

  mbx_seg_rules #(.MAX_SEQ(MAX_SEQ), .SEG_BYTES(SEG_BYTES), .LAST_MAX(LAST_MAX)) u_rules (
    .cur_i(cur), .seq_i(seg_seq_i), .len_i(seg_len_i), .mid_i(seg_mid_i),
    .mod_i(seg_mod_i), .cmd_i(seg_cmd_i), .ok_o(ok), .first_o(first)
  );

  mbx_resp_waiter u_wait (
    .clk(clk), .rst(rst), .req_start_i(req_start_i), .req_id_i(req_id_i),
    .hit_i(take && seg_last_i && seg_dir_i), .hit_id_i(seg_mid_i),
    .match_o(rsp_match_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o     <= 1'b0;
      seg_err_o   <= 1'b0;
      msg_done_o  <= 1'b0;
      wr_sel_o    <= '0;
      wr_line_o   <= '0;
      wr_be_o     <= '0;
      wr_data_o   <= '0;
      done_sel_o  <= '0;
      done_len_o  <= '0;
      done_stat_o <= '0;
    end else begin
      wr_en_o    <= take;
      seg_err_o  <= seg_valid_i && !ok;
      msg_done_o <= take && seg_last_i;
      if (take) begin
        wr_sel_o  <= sel;
        wr_line_o <= seg_seq_i;
        wr_be_o   <= be_next;
        wr_data_o <= seg_data_i;
      end
      if (take && seg_last_i) begin
        done_sel_o  <= sel;
        done_len_o  <= seg_mlen_i;
        done_stat_o <= seg_stat_i;
      end
    end
  end

  // R11
  err_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_o && seg_err_o));

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(seg_valid_i) |-> !(wr_en_o || seg_err_o || msg_done_o));

  // R1
  range_chk: assert property (@(posedge clk) disable iff (rst)
    (seg_valid_i && ((seg_seq_i > SEQ_W'(MAX_SEQ)) || (seg_len_i > LEN_W'(SEG_BYTES))))
    |=> seg_err_o);

  // R7
  done_wr_chk: assert property (@(posedge clk) disable iff (rst)
    msg_done_o |-> wr_en_o && (done_sel_o == wr_sel_o));

  // R9
  match_done_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_match_o |-> msg_done_o && done_sel_o[1]);

  // R6
  line_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> wr_line_o <= SEQ_W'(MAX_SEQ));
endmodule

// File: tb/tb_mbx_seg_reasm.sv
module tb_mbx_seg_reasm;
  import mbx_reasm_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seg_valid = 1'b0, seg_dir = 1'b0, seg_last = 1'b0;
  logic [FUNC_W-1:0] seg_src = '0;
  logic [SEQ_W-1:0] seg_seq = '0;
  logic [LEN_W-1:0] seg_len = '0;
  logic [MID_W-1:0] seg_mid = '0;
  logic [MOD_W-1:0] seg_mod = '0;
  logic [CMD_W-1:0] seg_cmd = '0;
  logic [MLEN_W-1:0] seg_mlen = '0;
  logic [STAT_W-1:0] seg_stat = '0;
  logic [383:0] seg_data = '0;
  logic req_start = 1'b0;
  logic [MID_W-1:0] req_id = '0;

  logic wr_en, seg_err, msg_done, rsp_match;
  logic [1:0] wr_sel, done_sel;
  logic [5:0] wr_line;
  logic [47:0] wr_be;
  logic [383:0] wr_data;
  logic [11:0] done_len;
  logic [7:0] done_stat;

  always #10 clk = ~clk;

  mbx_seg_reasm dut (
    .clk(clk), .rst(rst), .seg_valid_i(seg_valid), .seg_dir_i(seg_dir),
    .seg_src_i(seg_src), .seg_seq_i(seg_seq), .seg_len_i(seg_len),
    .seg_last_i(seg_last), .seg_mid_i(seg_mid), .seg_mod_i(seg_mod),
    .seg_cmd_i(seg_cmd), .seg_mlen_i(seg_mlen), .seg_stat_i(seg_stat),
    .seg_data_i(seg_data), .req_start_i(req_start), .req_id_i(req_id),
    .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_line_o(wr_line), .wr_be_o(wr_be),
    .wr_data_o(wr_data), .seg_err_o(seg_err), .msg_done_o(msg_done),
    .done_sel_o(done_sel), .done_len_o(done_len), .done_stat_o(done_stat),
    .rsp_match_o(rsp_match)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [383:0] act, input logic [383:0] exp);
    n_chk++;
    if (!good) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_seq[4], m_mid[4], m_mod[4], m_cmd[4];
  bit m_fresh[4];
  bit armed = 0;
  int pend = 0;
  bit e_on = 0, e_wr = 0, e_err = 0, e_done = 0, e_match = 0;
  int e_sel, e_line, e_len, e_st, e_dsel;
  logic [47:0] e_be;
  logic [383:0] e_data;
  string e_why = "R11";

  always @(posedge clk) begin
    e_wr = 0; e_err = 0; e_done = 0; e_match = 0; e_why = "R11";
    e_on = !rst;
    if (rst) begin
      for (int d = 0; d < 4; d++) begin m_seq[d] = 42; m_fresh[d] = 1; end
      armed = 0;
    end else begin
      if (seg_valid) begin
        int d, s, l;
        bit acc;
        d = seg_dir * 2 + ((seg_src == 13'h1FFF) ? 1 : 0);
        s = seg_seq; l = seg_len; acc = 0;
        if (s > 42 || l > 48) e_why = "R1";
        else if (s == 42 && l > 32) e_why = "R2";
        else if (s == 0) begin
          acc = 1; e_why = "R3"; m_fresh[d] = 0;
          m_mid[d] = seg_mid; m_mod[d] = seg_mod; m_cmd[d] = seg_cmd;
        end else if (m_seq[d] == 42) e_why = m_fresh[d] ? "R10" : "R5";
        else if (s == m_seq[d] + 1 && seg_mid == m_mid[d] && seg_mod == m_mod[d]
                 && seg_cmd == m_cmd[d]) begin
          acc = 1; e_why = (s == 42) ? "R2" : "R4";
        end else e_why = "R4";
        if (acc) begin
          m_seq[d] = s;
          e_wr = 1; e_sel = d; e_line = s; e_data = seg_data;
          for (int b = 0; b < 48; b++) e_be[b] = (b < l);
          if (seg_last) begin
            e_done = 1; e_dsel = d; e_len = seg_mlen; e_st = seg_stat;
            if (seg_dir && !req_start && armed && seg_mid == pend) begin
              e_match = 1; armed = 0;
            end
          end
        end else begin
          m_seq[d] = 42; e_err = 1;
        end
      end
      if (req_start) begin armed = 1; pend = req_id; end
    end
  end

  always @(negedge clk) begin
    if (e_on && !finished) begin
      chk(wr_en == e_wr, e_why, "write strobe", wr_en, e_wr);
      chk(seg_err == e_err, e_why, "error pulse", seg_err, e_err);
      chk(msg_done == e_done, "R7", "done pulse", msg_done, e_done);
      chk(rsp_match == e_match, "R9", "match pulse", rsp_match, e_match);
      if (e_wr) begin
        chk(wr_sel == e_sel[1:0], "R8", "descriptor", wr_sel, e_sel);
        chk(wr_line == e_line[5:0], "R6", "line", wr_line, e_line);
        chk(wr_be == e_be, "R6", "byte enables", wr_be, e_be);
        chk(wr_data == e_data, "R6", "data", wr_data, e_data);
      end
      if (e_done) begin
        chk(done_sel == e_dsel[1:0], "R7", "done descriptor", done_sel, e_dsel);
        chk(done_len == e_len[11:0], "R7", "length", done_len, e_len);
        chk(done_stat == e_st[7:0], "R7", "status", done_stat, e_st);
      end
    end
  end

  task automatic seg(input bit dir, input int src, input int seq, input int len,
                     input bit last, input int mid, input int md, input int cmd,
                     input int mlen, input int st);
    seg_valid = 1; seg_dir = dir; seg_src = FUNC_W'(src); seg_seq = SEQ_W'(seq);
    seg_len = LEN_W'(len); seg_last = last; seg_mid = MID_W'(mid);
    seg_mod = MOD_W'(md); seg_cmd = CMD_W'(cmd); seg_mlen = MLEN_W'(mlen);
    seg_stat = STAT_W'(st);
    for (int k = 0; k < 12; k++)
      seg_data[k*32 +: 32] = 32'h5A000000 + 32'(src * 4096 + seq * 16 + k);
    @(negedge clk);
    seg_valid = 0;
  endtask

  task automatic req(input int id);
    req_start = 1; req_id = MID_W'(id);
    @(negedge clk);
    req_start = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    idle(3);
    // R10: outputs held low in reset
    chk({wr_en, seg_err, msg_done, rsp_match} == 4'b0, "R10", "reset outputs",
        {wr_en, seg_err, msg_done, rsp_match}, 0);
    rst = 0;
    idle(2);
    // R10: continuation first after reset is rejected
    seg(0, 5, 1, 48, 0, 1, 2, 3, 0, 0);
    // R3 R6 R7: three-segment request
    seg(0, 5, 0, 48, 0, 1, 2, 3, 106, 0);
    seg(0, 5, 1, 48, 0, 1, 2, 3, 106, 0);
    seg(0, 5, 2, 10, 1, 1, 2, 3, 106, 0);
    idle(1);
    // R4 R5: skipped sequence, then poisoned continuation, then restart
    seg(0, 5, 0, 48, 0, 2, 2, 3, 0, 0);
    seg(0, 5, 2, 48, 0, 2, 2, 3, 0, 0);
    seg(0, 5, 3, 48, 0, 2, 2, 3, 0, 0);
    seg(0, 5, 0, 20, 0, 2, 2, 3, 0, 0);
    seg(0, 5, 1, 48, 0, 2, 9, 3, 0, 0);
    seg(0, 5, 0, 48, 0, 2, 2, 3, 0, 0);
    seg(0, 5, 1, 48, 0, 3, 2, 3, 0, 0);
    seg(0, 5, 0, 48, 0, 2, 2, 3, 0, 0);
    seg(0, 5, 1, 48, 0, 2, 2, 4, 0, 0);
    // R1: range violations, then a zero-length single segment
    seg(0, 5, 43, 4, 1, 2, 2, 3, 0, 0);
    seg(0, 5, 0, 49, 1, 2, 2, 3, 0, 0);
    seg(0, 5, 0, 0, 1, 2, 2, 3, 0, 1);
    idle(2);
    // R2: final segment too long, then a full 2048-byte message
    for (int s = 0; s < 42; s++) seg(0, 5, s, 48, 0, 7, 1, 1, 2048, 0);
    seg(0, 5, 42, 33, 1, 7, 1, 1, 2048, 0);
    for (int s = 0; s < 42; s++) seg(0, 5, s, 48, 0, 7, 1, 1, 2048, 0);
    seg(0, 5, 42, 32, 1, 7, 1, 1, 2048, 0);
    idle(1);
    // R8: interleaved messages on separate descriptors
    seg(0, 13'h1FFF, 0, 48, 0, 4, 1, 1, 0, 0);
    seg(0, 9, 0, 48, 0, 5, 6, 6, 0, 0);
    seg(1, 9, 0, 48, 0, 6, 6, 6, 0, 0);
    seg(0, 13'h1FFF, 1, 7, 1, 4, 1, 1, 55, 2);
    seg(0, 9, 1, 3, 1, 5, 6, 6, 51, 0);
    seg(1, 9, 1, 9, 1, 6, 6, 6, 57, 0);
    idle(1);
    // R9: armed waiter, repeat without re-arming, wrong id, right id
    req(5);
    seg(1, 13'h1FFF, 0, 8, 1, 5, 3, 3, 8, 3);
    seg(1, 13'h1FFF, 0, 8, 1, 5, 3, 3, 8, 3);
    req(6);
    seg(1, 9, 0, 4, 1, 7, 3, 3, 4, 0);
    seg(1, 9, 0, 4, 1, 6, 3, 3, 4, 0);
    idle(3);
    summary();
  end
endmodule